// File: doc/BRIEF.md
# Pipelined-Address Local Bus Master

This block is the bus-master sequencer for a processor-style local bus. It takes one transaction at a time from an internal requester over a valid/acknowledge handshake and runs it as a bus cycle. Each cycle has an address phase, marked by a one-clock active-low address strobe, and a data phase. The data phase lasts until the slave pulls the active-low ready input low. Read data and a completion pulse go back to the requester when the cycle ends.

The slave can pull the active-low next-address input low during a data phase to ask for the next address early. If a request is already waiting, the controller then puts that address on the bus while the current data phase is still running. The following cycle then starts with its address already valid. Back-to-back traffic can keep this overlap going with two-clock cycles. A hold request hands the bus to another master, but only at a point where no cycle is open. The bus states are idle, hold, T1, T2, and the pipelined states T1P, T2P and T2I. The controller samples all bus inputs directly on the rising clock edge and uses a synchronous active-high reset.

Top module: `addr_pipe_bus_ctrl`

## Requirements
- R1: During reset and in the first clock after it, the controller is idle: `ads_n`=1, `req_ack`=0, `hold_ack`=0, `rsp_done`=0, `bus_oe`=1, and address, definition and write data are all zero. The first cycle after reset starts in T1.
- R2: From idle or hold, a waiting request starts a non-pipelined cycle in T1: `ads_n` is low for one clock. T1 is always followed by T2. `ready_n` and `next_addr_n` are ignored in T1.
- R3: A cycle ends at the edge where `ready_n` is sampled low in T2, T2P or T2I. In the next clock, `rsp_done` is high for one clock, and `rsp_rdata` holds the `bus_rdata` value sampled at that edge.
- R4: In T2 with `ready_n` high, or in T1P, `next_addr_n` sampled low while `req_valid` is high moves the controller to T2P. In the first T2P clock, `ads_n` is low, `req_ack` is high, and `bus_addr`/`bus_def` carry the new request.
- R5: `next_addr_n` sampled low with no request waiting moves the controller to T2I. T2I gives no strobe, and a request that arrives during T2I is not taken before the cycle ends.
- R6: T2, T2P and T2I repeat for as long as `ready_n` stays high. Only the first T2P clock strobes, and the issued address stays unchanged through the wait states.
- R7: A cycle that ends in T2P is followed at once by T1P, with no strobe. At that point `bus_wdata` switches to the pipelined request's write data, and a pending hold request is not granted.
- R8: A cycle that ends in T2 or T2I is not pipelined, even when `ready_n` and `next_addr_n` are low together. The next clock is T1 if `req_valid` is high, and idle otherwise.
- R9: Hold is granted only from idle, or at the end of a cycle that ended in T2 or T2I. In hold, `hold_ack`=1, `bus_oe`=0, `ads_n`=1, and address, definition and write data are zero. When hold is released, the controller goes to idle, or to T1 if a request is waiting.
- R10: `req_ack` is high for exactly the clock in which a request's address is first driven with `ads_n` low, and only after `req_valid` was sampled high. The requester holds its fields stable until that clock ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Requester has a transaction waiting |
| req_addr | input | AW | Transaction address |
| req_def | input | CW | Transaction cycle-definition bits |
| req_wdata | input | DW | Transaction write data |
| req_ack | output | 1 | Transaction accepted (address issued this clock) |
| rsp_done | output | 1 | One-clock pulse after a cycle ends |
| rsp_rdata | output | DW | Data captured when the cycle ended |
| hold_req | input | 1 | Another master asks for the bus |
| hold_ack | output | 1 | Bus released to the other master |
| ready_n | input | 1 | Active-low cycle termination from the slave |
| next_addr_n | input | 1 | Active-low request for an early next address |
| ads_n | output | 1 | Active-low address strobe |
| bus_addr | output | AW | Issued address |
| bus_def | output | CW | Issued cycle definition |
| bus_wdata | output | DW | Write data of the cycle in its data phase |
| bus_rdata | input | DW | Read data from the slave |
| bus_oe | output | 1 | Drive enable for address, definition and data outputs |

## Verification
The bench goes after the edges of the pipelined mode. It drives ready and next-address in T1, where a design that sampled them there would strobe a second time or finish a cycle after one clock. It drives ready and next-address together in T2, where a design that let next-address win would keep the old write data in the following cycle. It sends a request during T2I, which a faulty design would issue inside the running cycle. It raises hold during a T2P that is ending, where early granting would drop the pipelined address. The bench also resets the controller while a pipelined address is outstanding: a controller that kept that address would start the next cycle in T1P with no strobe.

// File: rtl/pab_pkg.sv
package pab_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_T1,
        ST_T2,
        ST_T1P,
        ST_T2P,
        ST_T2I
    } bstate_e;

    // What the address/data slots do at the coming edge
    typedef enum logic [1:0] {
        OP_KEEP,
        OP_FRESH,    // load a request as a non-pipelined cycle
        OP_PIPE,     // load a request as the early (pipelined) address
        OP_PROMOTE   // early address becomes the active data phase
    } slot_op_e;

    // Bus inputs decoded to active-high, sampled at the clock edge
    typedef struct packed {
        logic want;
        logic ready;
        logic next_addr;
        logic hold;
    } sample_t;

    // Where the bus goes once no cycle is open
    function automatic bstate_e boundary_state(input sample_t s);
        if (s.hold)
            return ST_HOLD;
        else if (s.want)
            return ST_T1;
        else
            return ST_IDLE;
    endfunction

    function automatic logic in_data_phase(input bstate_e st);
        return (st == ST_T2) || (st == ST_T2P) || (st == ST_T2I);
    endfunction

    function automatic slot_op_e slot_action(input bstate_e cur, input bstate_e nxt);
        if (nxt == ST_T1)
            return OP_FRESH;
        else if (nxt == ST_T2P && cur != ST_T2P)
            return OP_PIPE;
        else if (nxt == ST_T1P)
            return OP_PROMOTE;
        else
            return OP_KEEP;
    endfunction

endpackage

// File: rtl/pab_fsm.sv
module pab_fsm
    import pab_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sample_t  smp,
    output bstate_e  state_q,
    output slot_op_e op,
    output logic     issue_q,
    output logic     hold_q,
    output logic     cyc_end
);

    bstate_e nxt;

    always_comb begin
        nxt = state_q;
        case (state_q)
            ST_IDLE, ST_HOLD: nxt = boundary_state(smp);
            ST_T1:            nxt = ST_T2;
            ST_T2: begin
                if (smp.ready)
                    nxt = boundary_state(smp);
                else if (smp.next_addr)
                    nxt = smp.want ? ST_T2P : ST_T2I;
            end
            ST_T1P: begin
                if (smp.next_addr)
                    nxt = smp.want ? ST_T2P : ST_T2I;
                else
                    nxt = ST_T2;
            end
            ST_T2P: begin
                if (smp.ready)
                    nxt = ST_T1P;
            end
            ST_T2I: begin
                if (smp.ready)
                    nxt = boundary_state(smp);
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign op      = slot_action(state_q, nxt);
    assign cyc_end = in_data_phase(state_q) && smp.ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            issue_q <= 1'b0;
            hold_q  <= 1'b0;
        end else begin
            state_q <= nxt;
            issue_q <= (op == OP_FRESH) || (op == OP_PIPE);
            hold_q  <= (nxt == ST_HOLD);
        end
    end

    // T1 always hands over to T2
    p_t1_then_t2_r2: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_T1 |=> state_q == ST_T2);

    // A cycle opened from idle or hold never starts pipelined
    p_open_nonpipe_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE || state_q == ST_HOLD)
        |=> (state_q == ST_IDLE || state_q == ST_HOLD || state_q == ST_T1));

    p_early_issue_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_T2 && !smp.ready && smp.next_addr && smp.want)
        |=> (state_q == ST_T2P && issue_q));

    p_no_req_t2i_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_T1P && smp.next_addr && !smp.want)
        |=> (state_q == ST_T2I && !issue_q));

    p_wait_t2i_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_T2I && !smp.ready) |=> state_q == ST_T2I);

    p_pipe_cont_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_T2P && smp.ready) |=> state_q == ST_T1P);

    p_plain_end_r8: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_T2 || state_q == ST_T2I) && smp.ready)
        |=> (state_q != ST_T1P && state_q != ST_T2P));

    p_hold_boundary_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_HOLD) ##1 (state_q == ST_HOLD)
        |-> ($past(state_q) == ST_IDLE || $past(state_q) == ST_T2 || $past(state_q) == ST_T2I));

endmodule

// File: rtl/pab_slots.sv
module pab_slots
    import pab_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 3,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  slot_op_e      op,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_def,
    input  logic [DW-1:0] req_wdata,
    output logic [AW-1:0] iss_addr,
    output logic [CW-1:0] iss_def,
    output logic [DW-1:0] cur_wdata
);

    logic [DW-1:0] pend_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_addr   <= '0;
            iss_def    <= '0;
            cur_wdata  <= '0;
            pend_wdata <= '0;
        end else begin
            case (op)
                OP_FRESH: begin
                    iss_addr  <= req_addr;
                    iss_def   <= req_def;
                    cur_wdata <= req_wdata;
                end
                OP_PIPE: begin
                    iss_addr   <= req_addr;
                    iss_def    <= req_def;
                    pend_wdata <= req_wdata;
                end
                OP_PROMOTE: cur_wdata <= pend_wdata;
                default: ;
            endcase
        end
    end

    // Entering T1P must not disturb the address already on the bus
    p_promote_keeps_addr_r7: assert property (@(posedge clk) disable iff (rst)
        op == OP_PROMOTE |=> $stable(iss_addr) && $stable(iss_def));

    p_wait_keeps_addr_r6: assert property (@(posedge clk) disable iff (rst)
        op == OP_KEEP |=> $stable(iss_addr));

endmodule

// File: rtl/pab_resp.sv
module pab_resp #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_end,
    input  logic [DW-1:0] bus_rdata,
    output logic          done_q,
    output logic [DW-1:0] rdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= cyc_end;
            if (cyc_end)
                rdata_q <= bus_rdata;
        end
    end

endmodule

// File: rtl/addr_pipe_bus_ctrl.sv
module addr_pipe_bus_ctrl
    import pab_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 3,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_def,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    input  logic          hold_req,
    output logic          hold_ack,
    input  logic          ready_n,
    input  logic          next_addr_n,
    output logic          ads_n,
    output logic [AW-1:0] bus_addr,
    output logic [CW-1:0] bus_def,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_oe
);

    sample_t       smp;
    bstate_e       state_q;
    slot_op_e      op;
    logic          issue_q;
    logic          hold_q;
    logic          cyc_end;
    logic [AW-1:0] iss_addr;
    logic [CW-1:0] iss_def;
    logic [DW-1:0] cur_wdata;

    assign smp.want      = req_valid;
    assign smp.ready     = ~ready_n;
    assign smp.next_addr = ~next_addr_n;
    assign smp.hold      = hold_req;

    pab_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .smp     (smp),
        .state_q (state_q),
        .op      (op),
        .issue_q (issue_q),
        .hold_q  (hold_q),
        .cyc_end (cyc_end)
    );

    pab_slots #(.AW(AW), .CW(CW), .DW(DW)) u_slots (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .req_addr  (req_addr),
        .req_def   (req_def),
        .req_wdata (req_wdata),
        .iss_addr  (iss_addr),
        .iss_def   (iss_def),
        .cur_wdata (cur_wdata)
    );

    pab_resp #(.DW(DW)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .cyc_end   (cyc_end),
        .bus_rdata (bus_rdata),
        .done_q    (rsp_done),
        .rdata_q   (rsp_rdata)
    );

    assign ads_n     = ~issue_q;
    assign req_ack   = issue_q;
    assign hold_ack  = hold_q;
    assign bus_oe    = ~hold_q;
    assign bus_addr  = hold_q ? '0 : iss_addr;
    assign bus_def   = hold_q ? '0 : iss_def;
    assign bus_wdata = hold_q ? '0 : cur_wdata;

    // Every cycle spans at least two clocks, so completions never touch
    p_done_gap_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        hold_ack |-> (ads_n && !req_ack));

    p_ack_after_req_r10: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> $past(req_valid));

    p_ack_single_r10: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

endmodule

// File: tb/tb_addr_pipe_bus_ctrl.sv
module tb_addr_pipe_bus_ctrl;

    localparam int AW = 32;
    localparam int CW = 3;
    localparam int DW = 32;
    localparam int NV = 35;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [CW-1:0] req_def;
    logic [DW-1:0] req_wdata;
    logic          req_ack;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic          hold_req;
    logic          hold_ack;
    logic          ready_n;
    logic          next_addr_n;
    logic          ads_n;
    logic [AW-1:0] bus_addr;
    logic [CW-1:0] bus_def;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          bus_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    addr_pipe_bus_ctrl #(.AW(AW), .CW(CW), .DW(DW)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_def(req_def), .req_wdata(req_wdata),
        .req_ack(req_ack), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .hold_req(hold_req), .hold_ack(hold_ack),
        .ready_n(ready_n), .next_addr_n(next_addr_n),
        .ads_n(ads_n), .bus_addr(bus_addr), .bus_def(bus_def), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_oe(bus_oe)
    );

    // One row per bus clock: expected outputs of the present state, then the
    // inputs applied during that state.
    typedef struct packed {
        logic [3:0] tag;
        logic       rv;
        logic [7:0] ra;
        logic       rdy_n;
        logic       na_n;
        logic       hold;
        logic       e_ads_n;
        logic       e_ack;
        logic       e_hack;
        logic       e_done;
        logic [7:0] e_a;
        logic [7:0] e_w;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{4'd1,  1'b1, 8'h11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00}, // 0 idle (R1)
        '{4'd2,  1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 8'h11}, // 1 T1, ready ignored (R2)
        '{4'd2,  1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h11}, // 2 T2
        '{4'd3,  1'b1, 8'h22, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h11}, // 3 T2 ends (R3)
        '{4'd8,  1'b1, 8'h22, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h22, 8'h22}, // 4 T1 (R8)
        '{4'd4,  1'b1, 8'h33, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h22, 8'h22}, // 5 T2 + next addr (R4)
        '{4'd4,  1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h33, 8'h22}, // 6 T2P first
        '{4'd6,  1'b1, 8'h44, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h33, 8'h22}, // 7 T2P wait (R6)
        '{4'd7,  1'b1, 8'h44, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h33, 8'h33}, // 8 T1P (R7)
        '{4'd7,  1'b1, 8'h44, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h44, 8'h33}, // 9 T2P two-clock cycle
        '{4'd5,  1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h44, 8'h44}, // 10 T1P, no request (R5)
        '{4'd5,  1'b1, 8'h55, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h44, 8'h44}, // 11 T2I, late request
        '{4'd6,  1'b1, 8'h55, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h44, 8'h44}, // 12 T2I wait then end
        '{4'd8,  1'b1, 8'h55, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h55, 8'h55}, // 13 T1, hold mid-cycle
        '{4'd9,  1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 8'h55}, // 14 T2 ends into hold (R9)
        '{4'd9,  1'b1, 8'h66, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00}, // 15 hold
        '{4'd9,  1'b1, 8'h66, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00}, // 16 hold release
        '{4'd2,  1'b1, 8'h66, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h66, 8'h66}, // 17 T1, next addr ignored
        '{4'd2,  1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h66, 8'h66}, // 18 T2 ends
        '{4'd8,  1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h66, 8'h66}, // 19 idle, hold asked
        '{4'd9,  1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00}, // 20 hold from idle
        '{4'd10, 1'b1, 8'h77, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h66, 8'h66}, // 21 idle (R10)
        '{4'd10, 1'b1, 8'h77, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h77, 8'h77}, // 22 T1
        '{4'd8,  1'b1, 8'h88, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h77, 8'h77}, // 23 T2 ready+next addr
        '{4'd8,  1'b1, 8'h88, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h88, 8'h88}, // 24 T1, not T2P
        '{4'd3,  1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h88, 8'h88}, // 25 T2 ends
        '{4'd3,  1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h88, 8'h88}, // 26 idle
        '{4'd2,  1'b1, 8'h99, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h88, 8'h88}, // 27 idle
        '{4'd2,  1'b1, 8'h99, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h99, 8'h99}, // 28 T1
        '{4'd4,  1'b1, 8'hAA, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h99, 8'h99}, // 29 T2 + next addr
        '{4'd7,  1'b1, 8'hAA, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hAA, 8'h99}, // 30 T2P ends, hold asked
        '{4'd7,  1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hAA, 8'hAA}, // 31 T1P, hold refused
        '{4'd9,  1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hAA, 8'hAA}, // 32 T2 ends into hold
        '{4'd9,  1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00}, // 33 hold
        '{4'd9,  1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hAA, 8'hAA}  // 34 idle
    };

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] wd_of(input logic [7:0] b);
        return (b == 8'h00) ? 32'h0 : (32'hCAFE_0000 | {24'h0, b});
    endfunction

    task automatic drive(input logic rv, input logic [7:0] ra, input logic rn,
                         input logic nn, input logic hr);
        req_valid   = rv;
        req_addr    = {24'h0, ra};
        req_def     = ra[2:0];
        req_wdata   = 32'hCAFE_0000 | {24'h0, ra};
        ready_n     = rn;
        next_addr_n = nn;
        hold_req    = hr;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        bus_rdata = '0;
        drive(1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d row%0d", VEC[i].tag, i);
            chk(rq, "ads_n",     {31'h0, ads_n},    {31'h0, VEC[i].e_ads_n});
            chk(rq, "req_ack",   {31'h0, req_ack},  {31'h0, VEC[i].e_ack});
            chk(rq, "hold_ack",  {31'h0, hold_ack}, {31'h0, VEC[i].e_hack});
            chk(rq, "bus_oe",    {31'h0, bus_oe},   {31'h0, ~VEC[i].e_hack});
            chk(rq, "rsp_done",  {31'h0, rsp_done}, {31'h0, VEC[i].e_done});
            chk(rq, "bus_addr",  bus_addr,          {24'h0, VEC[i].e_a});
            chk(rq, "bus_def",   {29'h0, bus_def},  {29'h0, VEC[i].e_a[2:0]});
            chk(rq, "bus_wdata", bus_wdata,         wd_of(VEC[i].e_w));
            if (VEC[i].e_done)
                chk(rq, "rsp_rdata (R3)", rsp_rdata, 32'hD000_0000 | (i - 1));
            bus_rdata = 32'hD000_0000 | i;
            drive(VEC[i].rv, VEC[i].ra, VEC[i].rdy_n, VEC[i].na_n, VEC[i].hold);
            step();
        end

        // Directed: reset while an early address is outstanding (R1)
        drive(1'b1, 8'hBB, 1'b1, 1'b1, 1'b0);
        step();
        chk("R2", "T1 strobe", {31'h0, ads_n}, 32'h0);
        drive(1'b1, 8'hBB, 1'b1, 1'b1, 1'b0);
        step();
        drive(1'b1, 8'hCC, 1'b1, 1'b0, 1'b0);
        step();
        chk("R4", "T2P ack", {31'h0, req_ack}, 32'h1);
        chk("R4", "T2P addr", bus_addr, 32'h0000_00CC);
        rst = 1'b1;
        step();
        chk("R1", "reset ads_n", {31'h0, ads_n}, 32'h1);
        chk("R1", "reset req_ack", {31'h0, req_ack}, 32'h0);
        chk("R1", "reset hold_ack", {31'h0, hold_ack}, 32'h0);
        chk("R1", "reset rsp_done", {31'h0, rsp_done}, 32'h0);
        chk("R1", "reset bus_addr", bus_addr, 32'h0);
        chk("R1", "reset bus_wdata", bus_wdata, 32'h0);
        rst = 1'b0;
        drive(1'b1, 8'hDD, 1'b0, 1'b1, 1'b0);
        step();
        chk("R1", "first cycle strobes in T1", {31'h0, ads_n}, 32'h0);
        chk("R1", "first cycle ack", {31'h0, req_ack}, 32'h1);
        chk("R1", "first cycle addr", bus_addr, 32'h0000_00DD);
        chk("R1", "first cycle wdata", bus_wdata, 32'hCAFE_00DD);
        drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        step();
        chk("R2", "ready in T1 ignored", {31'h0, rsp_done}, 32'h0);
        bus_rdata = 32'h1234_5678;
        drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        step();
        chk("R3", "done after T2 ready", {31'h0, rsp_done}, 32'h1);
        chk("R3", "read data", rsp_rdata, 32'h1234_5678);
        drive(1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
        step();
        chk("R8", "idle after plain end", {31'h0, ads_n}, 32'h1);
        chk("R3", "done is one clock", {31'h0, rsp_done}, 32'h0);

        finish_run();
    end

endmodule